// File: doc/BRIEF.md
# Marker-Framed Serial Uplink Receiver

This block listens to one asynchronous serial wire. The wire carries a high burst window of variable length, and a fixed 25-bit status frame follows that window. The falling edge that ends the burst is also the first bit of a four-bit marker, 0 then 1, 1, 0. The receiver times every bit from that edge with a local cycle counter. It takes the first sample a configurable offset after the edge and each later sample one bit period after the one before.

The receiver checks the marker bit by bit. If any marker bit is wrong, it gives up on the frame and pulses an error strobe. When all 25 bits arrive intact, it decodes the following and holds them on parallel outputs, with a one-cycle valid strobe:

- a 16-bit word
- a command-mode flag, with a view that splits the word into a command nibble and a 12-bit payload
- a reset-request flag
- two diagnostic-select bits
- an LED request

The outputs keep their values until the next good frame. The bit period and the first-sample offset are parameters, both counted in local clock cycles. Together they let a local clock that is not a multiple of the sender's rate still stay centred across the whole frame.

Top module: `uplink_frame_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `rx_valid` and `rx_err` are 0 and every decoded output is 0. Reset puts the receiver in its hunt state.
- R2: A line that has stayed low since reset never starts a frame. No strobe appears until the line has been seen high and has then fallen.
- R3: After the line has been high, a falling edge starts a frame. The edge reaches the receiver through a two-flop synchronizer, so it is detected two cycles after the input changes. Bit 1 is sampled FIRST_OFS cycles after that detection, and bit k is sampled (k-1)*BIT_CYC cycles after bit 1. `rx_valid` rises in the cycle after the bit-25 sample, which is 3+FIRST_OFS+24*BIT_CYC clock edges after the input falls.
- R4: Frame bits 1 to 4 must read 0,1,1,0. At the first marker bit that does not match, `rx_err` pulses for exactly one cycle, no `rx_valid` appears for that frame, and the decoded outputs keep their previous values.
- R5: After a framing error the receiver goes back to hunting. A line that stays low afterwards starts nothing, and a later high then fall starts a new frame that decodes normally. A short low glitch inside the burst is caught this way: bit 1 is sampled high, so `rx_err` pulses, and the real frame that follows is still received.
- R6: Frame bits 5 to 20 form `data_word`, with bit 5 as the MSB and bit 20 as the LSB.
- R7: `cmd_mode` is frame bit 22. `cmd_nib` always shows `data_word[15:12]`, and `payload` always shows `data_word[11:0]`.
- R8: `rst_req` is frame bit 21 and `led_req` is frame bit 25, where 1 means on. `diag_sel[1]` is frame bit 23 and `diag_sel[0]` is frame bit 24.
- R9: A good frame produces a `rx_valid` pulse exactly one cycle wide. The decoded outputs change only together with that pulse and stay stable at all other times.
- R10: The frame is still decoded correctly when the sender's bit period differs from BIT_CYC by one cycle in 64, whether faster or slower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial uplink line |
| rx_valid | output | 1 | One-cycle strobe: a good frame was decoded |
| rx_err | output | 1 | One-cycle strobe: marker mismatch, frame abandoned |
| data_word | output | 16 | Decoded 16-bit word, held until the next good frame |
| cmd_nib | output | 4 | Upper four bits of the word, used as a command |
| payload | output | 12 | Lower twelve bits of the word, used as command data |
| cmd_mode | output | 1 | Set when the word is to be read as command plus payload |
| rst_req | output | 1 | Reset-request flag from the frame |
| diag_sel | output | 2 | Diagnostic-select bits, zero in normal operation |
| led_req | output | 1 | LED request, 1 means on |

## Verification
The hardest case to reach from the ports is a falling edge that is not a real frame start: a low glitch of a few cycles inside a long burst. The receiver must take this glitch as bit 1, sample it high one offset later, reject it, then re-arm on the still-high line and catch the true frame that follows. The stimulus builds this by hand. It drives a high stretch, then three low cycles, then another high stretch longer than the first-sample offset, then a complete frame. A second hand-built case sends a bad marker followed by a long low tail, to show that the receiver stays idle until the line goes high again. Timing tolerance is covered by sending frames whose bit period is one cycle longer or shorter than the receiver's.

// File: rtl/ufr_pkg.sv
package ufr_pkg;

    localparam int FRAME_BITS = 25;
    localparam int MARK_BITS  = 4;
    localparam int DATA_W     = 16;
    localparam int CMD_W      = 4;
    localparam int PAY_W      = DATA_W - CMD_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    // Marker as sent: first bit on the wire is the MSB.
    localparam logic [MARK_BITS-1:0] MARKER = 4'b0110;

    // Positions inside a frame vector whose MSB is frame bit 1.
    localparam int WORD_HI  = FRAME_BITS - MARK_BITS - 1;
    localparam int RREQ_POS = WORD_HI - DATA_W;
    localparam int MODE_POS = RREQ_POS - 1;
    localparam int DIAG_HI  = MODE_POS - 1;
    localparam int LED_POS  = 0;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RECV  = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              rst_req;
        logic              cmd_mode;
        logic [1:0]        diag;
        logic              led;
    } frame_fields_t;

endpackage

// File: rtl/ufr_sync.sv
module ufr_sync (
    input  logic clk,
    input  logic rst,
    input  logic line_async,
    output logic line_hi,
    output logic line_fall
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= line_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign line_hi   = sync_q;
    assign line_fall = prev_q & ~sync_q;
endmodule

// File: rtl/ufr_bit_timer.sv
module ufr_bit_timer #(
    parameter int BIT_CYC   = 128,
    parameter int FIRST_OFS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic tick
);
    localparam int CNT_MAX = (BIT_CYC > FIRST_OFS) ? BIT_CYC : FIRST_OFS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (start) begin
            cnt_d = CNT_W'(FIRST_OFS - 1);
        end else if (run) begin
            if (cnt_q == '0) begin
                tick  = 1'b1;
                cnt_d = CNT_W'(BIT_CYC - 1);
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ufr_decode.sv
module ufr_decode
    import ufr_pkg::*;
(
    input  logic [FRAME_BITS-1:0] frame,
    output frame_fields_t         fields
);
    always_comb begin
        fields.word     = frame[WORD_HI -: DATA_W];
        fields.rst_req  = frame[RREQ_POS];
        fields.cmd_mode = frame[MODE_POS];
        fields.diag     = frame[DIAG_HI -: 2];
        fields.led      = frame[LED_POS];
    end

    // Marker bits are checked by the receiver as they arrive.
    logic [MARK_BITS-1:0] marker_unused;
    assign marker_unused = frame[FRAME_BITS-1 -: MARK_BITS];
endmodule

// File: rtl/uplink_frame_rx.sv
module uplink_frame_rx
    import ufr_pkg::*;
#(
    parameter int BIT_CYC   = 128,
    parameter int FIRST_OFS = BIT_CYC / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_in,
    output logic              rx_valid,
    output logic              rx_err,
    output logic [DATA_W-1:0] data_word,
    output logic [CMD_W-1:0]  cmd_nib,
    output logic [PAY_W-1:0]  payload,
    output logic              cmd_mode,
    output logic              rst_req,
    output logic [1:0]        diag_sel,
    output logic              led_req
);
    typedef struct packed {
        rx_state_e             st;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-2:0] shreg;
        frame_fields_t         held;
        logic                  valid;
        logic                  err;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic line_hi, line_fall;
    logic tmr_start, tmr_run, tmr_tick;
    logic [FRAME_BITS-1:0] shifted;
    frame_fields_t         dec;
    logic                  exp_bit;
    logic                  in_marker;

    ufr_sync sync_i (
        .clk       (clk),
        .rst       (rst),
        .line_async(rx_in),
        .line_hi   (line_hi),
        .line_fall (line_fall)
    );

    ufr_bit_timer #(
        .BIT_CYC  (BIT_CYC),
        .FIRST_OFS(FIRST_OFS)
    ) timer_i (
        .clk  (clk),
        .rst  (rst),
        .start(tmr_start),
        .run  (tmr_run),
        .tick (tmr_tick)
    );

    assign shifted = {r_q.shreg, line_hi};

    ufr_decode dec_i (
        .frame (shifted),
        .fields(dec)
    );

    always_comb begin
        exp_bit = 1'b0;
        for (int i = 0; i < MARK_BITS; i++) begin
            if (r_q.idx == IDX_W'(i)) exp_bit = MARKER[MARK_BITS-1-i];
        end
        in_marker = (r_q.idx < IDX_W'(MARK_BITS));
    end

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.err   = 1'b0;
        tmr_start = 1'b0;
        tmr_run   = (r_q.st == ST_RECV);
        case (r_q.st)
            ST_HUNT: begin
                if (line_hi) r_d.st = ST_ARMED;
            end
            ST_ARMED: begin
                if (line_fall) begin
                    tmr_start = 1'b1;
                    r_d.st    = ST_RECV;
                    r_d.idx   = '0;
                end
            end
            ST_RECV: begin
                if (tmr_tick) begin
                    r_d.shreg = shifted[FRAME_BITS-2:0];
                    if (in_marker && (line_hi != exp_bit)) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_HUNT;
                    end else if (r_q.idx == IDX_W'(FRAME_BITS - 1)) begin
                        r_d.held  = dec;
                        r_d.valid = 1'b1;
                        r_d.st    = ST_HUNT;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign rx_valid  = r_q.valid;
    assign rx_err    = r_q.err;
    assign data_word = r_q.held.word;
    assign cmd_nib   = r_q.held.word[DATA_W-1 -: CMD_W];
    assign payload   = r_q.held.word[PAY_W-1:0];
    assign cmd_mode  = r_q.held.cmd_mode;
    assign rst_req   = r_q.held.rst_req;
    assign diag_sel  = r_q.held.diag;
    assign led_req   = r_q.held.led;
endmodule

// File: rtl/ufr_chk.sv
module ufr_chk (
    input logic        clk,
    input logic        rst,
    input logic        rx_valid,
    input logic        rx_err,
    input logic [15:0] data_word,
    input logic        cmd_mode,
    input logic        rst_req,
    input logic [1:0]  diag_sel,
    input logic        led_req
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!rx_valid && !rx_err && data_word == '0));

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_err));

    assert_err_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rx_err |=> !rx_err);

    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_hold_fields_R9: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable({data_word, cmd_mode, rst_req, diag_sel, led_req}));
endmodule

bind uplink_frame_rx ufr_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_err   (rx_err),
    .data_word(data_word),
    .cmd_mode (cmd_mode),
    .rst_req  (rst_req),
    .diag_sel (diag_sel),
    .led_req  (led_req)
);

// File: tb/uplink_frame_rx_tb_top.sv
`timescale 1ns/1ps
module uplink_frame_rx_tb_top;
    localparam int BIT = 64;
    localparam int OFS = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_in = 1'b0;
    logic rx_valid, rx_err, cmd_mode, rst_req, led_req;
    logic [15:0] data_word;
    logic [3:0]  cmd_nib;
    logic [11:0] payload;
    logic [1:0]  diag_sel;

    uplink_frame_rx #(.BIT_CYC(BIT), .FIRST_OFS(OFS)) dut_i (
        .clk(clk), .rst(rst), .rx_in(rx_in),
        .rx_valid(rx_valid), .rx_err(rx_err), .data_word(data_word),
        .cmd_nib(cmd_nib), .payload(payload), .cmd_mode(cmd_mode),
        .rst_req(rst_req), .diag_sel(diag_sel), .led_req(led_req)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int n_valid = 0;
    int n_err = 0;
    int valid_cyc = 0;
    int fall_cyc = 0;

    always @(posedge clk) cyc++;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, updated at each rising edge.
    int m_q1 = 0, m_q2 = 0, m_pv = 0, m_st = 0, m_cnt = 0, m_idx = 0;
    logic [24:0] m_fr = '0;
    logic m_valid = 0, m_err = 0;
    logic [15:0] m_word = '0;
    logic [4:0]  m_flags = '0;   // {rst_req, cmd_mode, diag[1:0], led}

    always @(posedge clk) begin
        if (rst) begin
            m_q1 = 0; m_q2 = 0; m_pv = 0; m_st = 0; m_cnt = 0; m_idx = 0;
            m_valid = 0; m_err = 0; m_word = '0; m_flags = '0; m_fr = '0;
        end else begin
            int fall;
            int hi;
            logic [3:0] mk;
            mk = 4'b0110;
            hi = m_q2;
            fall = (m_pv == 1 && m_q2 == 0) ? 1 : 0;
            m_valid = 0;
            m_err = 0;
            if (m_st == 0) begin
                if (hi == 1) m_st = 1;
            end else if (m_st == 1) begin
                if (fall == 1) begin m_st = 2; m_cnt = OFS - 1; m_idx = 0; end
            end else begin
                if (m_cnt == 0) begin
                    m_cnt = BIT - 1;
                    m_fr = {m_fr[23:0], hi[0]};
                    if (m_idx < 4 && hi[0] != mk[3 - m_idx]) begin
                        m_err = 1; m_st = 0;
                    end else if (m_idx == 24) begin
                        m_valid = 1; m_st = 0;
                        m_word = m_fr[20:5];
                        m_flags = m_fr[4:0];
                    end else begin
                        m_idx++;
                    end
                end else begin
                    m_cnt--;
                end
            end
            m_pv = m_q2;
            m_q2 = m_q1;
            m_q1 = int'(rx_in);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin n_valid++; valid_cyc = cyc; end
            if (rx_err) n_err++;
            chk("R9", "model valid", rx_valid, m_valid);
            chk("R4", "model err", rx_err, m_err);
            chk("R6", "model word", data_word, m_word);
            chk("R8", "model flags", {rst_req, cmd_mode, diag_sel, led_req}, m_flags);
            chk("R7", "model split", {cmd_nib, payload}, m_word);
        end
    end

    task automatic hold(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            rx_in = v;
            @(negedge clk);
        end
    endtask

    task automatic send(input int burst, input logic [24:0] f, input int per);
        hold(1'b1, burst);
        fall_cyc = cyc;
        for (int k = 24; k >= 0; k--) hold(f[k], per);
    endtask

    function automatic logic [24:0] mkf(input logic [15:0] w, input logic rr,
                                        input logic md, input logic [1:0] dg, input logic ld);
        return {4'b0110, w, rr, md, dg, ld};
    endfunction

    task automatic expect_frame(input string req, input int nv0, input logic [15:0] w,
                                input logic rr, input logic md, input logic [1:0] dg, input logic ld);
        chk(req, "valid count", n_valid, nv0 + 1);
        chk(req, "word", data_word, w);
        chk(req, "rst_req", rst_req, rr);
        chk(req, "cmd_mode", cmd_mode, md);
        chk(req, "diag", diag_sel, dg);
        chk(req, "led", led_req, ld);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int nv;
        int ne;
        @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R1", "valid in reset", rx_valid, 0);
        chk("R1", "err in reset", rx_err, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "outputs after reset", {data_word, cmd_mode, rst_req, diag_sel, led_req, rx_valid}, 0);

        // R2: low idle line starts nothing.
        hold(1'b0, 300);
        chk("R2", "no valid on low line", n_valid, 0);
        chk("R2", "no err on low line", n_err, 0);

        // R3, R6, R8: nominal frame and its timing.
        nv = n_valid;
        send(100, mkf(16'hA53C, 1'b1, 1'b0, 2'b00, 1'b1), BIT);
        expect_frame("R6", nv, 16'hA53C, 1'b1, 1'b0, 2'b00, 1'b1);
        chk("R3", "valid cycle", valid_cyc, fall_cyc + 3 + OFS + 24 * BIT);

        // R9: held with no new pulse.
        hold(1'b0, 200);
        chk("R9", "word held", data_word, 16'hA53C);
        chk("R9", "single pulse", n_valid, nv + 1);

        // R7: command mode split.
        nv = n_valid;
        send(57, mkf(16'h7123, 1'b0, 1'b1, 2'b00, 1'b0), BIT);
        expect_frame("R7", nv, 16'h7123, 1'b0, 1'b1, 2'b00, 1'b0);
        chk("R7", "cmd nibble", cmd_nib, 4'h7);
        chk("R7", "payload", payload, 12'h123);

        // R10, R8: sender slower and faster by one cycle in 64.
        nv = n_valid;
        send(90, mkf(16'h0001, 1'b0, 1'b0, 2'b10, 1'b1), BIT + 1);
        expect_frame("R10", nv, 16'h0001, 1'b0, 1'b0, 2'b10, 1'b1);
        nv = n_valid;
        send(70, mkf(16'hFFFE, 1'b1, 1'b1, 2'b01, 1'b0), BIT - 1);
        expect_frame("R10", nv, 16'hFFFE, 1'b1, 1'b1, 2'b01, 1'b0);
        chk("R8", "diag bit order", diag_sel, 2'b01);

        // R4, R5: bad third marker bit, then a low tail.
        nv = n_valid; ne = n_err;
        send(80, {4'b0100, 21'b0}, BIT);
        hold(1'b0, 300);
        chk("R4", "one error", n_err, ne + 1);
        chk("R4", "no valid on bad marker", n_valid, nv);
        chk("R4", "word kept", data_word, 16'hFFFE);
        chk("R5", "idle after error", n_err, ne + 1);

        nv = n_valid;
        send(60, mkf(16'h5AA5, 1'b0, 1'b0, 2'b00, 1'b1), BIT);
        expect_frame("R5", nv, 16'h5AA5, 1'b0, 1'b0, 2'b00, 1'b1);

        // R5: glitch inside a burst is rejected, real frame still received.
        nv = n_valid; ne = n_err;
        hold(1'b1, 150);
        hold(1'b0, 3);
        hold(1'b1, 150);
        chk("R5", "glitch error", n_err, ne + 1);
        send(50, mkf(16'hC0DE, 1'b0, 1'b1, 2'b00, 1'b0), BIT);
        expect_frame("R5", nv, 16'hC0DE, 1'b0, 1'b1, 2'b00, 1'b0);
        chk("R5", "no extra error", n_err, ne + 1);

        hold(1'b0, 100);
        summary();
        $finish;
    end
endmodule